// File: doc/BRIEF.md
# Special Character Flow Matcher

This block sits behind a serial character receiver. Each received character comes in with a one-cycle strobe and a flag that says whether it arrived without a parity, framing, break or overrun fault. Only clean characters are compared against four programmable character slots. Slots 1 and 2 act as the in-band flow-control pair (resume and pause). When transparent flow mode is on, they switch a transmit-enable output without host involvement. Slots 3 and 4 are reported to the host, either one at a time or as a two-character sequence.

A slot that has been lent to the transmit side for sending a special character is removed from comparison through a per-slot claim mask. Host-visible matches become a receive exception request that carries a 3-bit match code. The request is held until the host acknowledges it, and up to two pending requests wait in order. A suppress flag, valid in the same cycle as the strobe, tells the receive FIFO not to store a flow-control character that has been consumed.

Top module: `spchar_flow_matcher`

## Requirements
- R1: A character strobed with `rx_good` low changes nothing: no exception is queued, `suppress` stays low, `tx_en` keeps its value, and any partly matched sequence is abandoned.
- R2: After reset `tx_en` is 1, `exc_req` is 0 and `exc_code` is 0.
- R3: With `flow_en` high, a clean character equal to slot 1 sets `tx_en` from the next clock and one equal to slot 2 clears it. If both slots match, the clear wins. Neither character raises an exception.
- R4: With `flow_en` high, `suppress` is high in the strobe cycle exactly when the clean character matches slot 1 or slot 2, and low otherwise.
- R5: With `flow_en` low, `tx_en` is held at 1. Clean matches on slot 1 and slot 2 are reported with codes 1 and 2.
- R6: With `seq_mode` low, a clean match on slot 3 reports code 3 and one on slot 4 reports code 4. When a character matches several slots, only the lowest-numbered one is reported.
- R7: With `seq_mode` high, slots 3 and 4 are never reported alone. A clean slot-3 character immediately followed by a clean slot-4 character reports code 5. Any other character in between cancels the pair, but a repeated slot-3 character re-arms it.
- R8: Bit i of `slot_tx_claim` (bit 0 = slot 1) removes slot i+1 from all comparison, so a claimed slot causes neither a report, a flow change nor a suppress.
- R9: An event raises `exc_req` from the clock edge after its strobe. `exc_code` stays stable until `exc_ack` is high while `exc_req` is high, and that acknowledge retires the head entry.
- R10: At most two events are pending, presented in arrival order. An event that arrives while two are pending is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe of a received character |
| rx_data | input | DATA_W | Received character |
| rx_good | input | 1 | Character received without any error |
| slot1_char | input | DATA_W | Slot 1, resume (XON) character |
| slot2_char | input | DATA_W | Slot 2, pause (XOFF) character |
| slot3_char | input | DATA_W | Slot 3, first host character / pair head |
| slot4_char | input | DATA_W | Slot 4, second host character / pair tail |
| slot_tx_claim | input | 4 | Per-slot mask; set = slot lent to transmit, not compared |
| flow_en | input | 1 | Transparent flow control on slots 1 and 2 |
| seq_mode | input | 1 | Slots 3 and 4 form a two-character sequence |
| exc_ack | input | 1 | Host acknowledge of the head exception |
| exc_req | output | 1 | Receive exception request pending |
| exc_code | output | 3 | Match code of head entry: 1-4 slot, 5 pair, 0 none |
| tx_en | output | 1 | Transmitter enable |
| suppress | output | 1 | Do not store the strobed character (same cycle) |

## Verification
A wrong pause/resume state shows on `tx_en` one clock after the offending strobe and persists until the next flow character. A missing or stale sequence arm shows only when the next clean character arrives: a pair is reported that should not be, or a real pair is lost. A queue fault shows as a changed or missing `exc_code` at the next acknowledge, or as a request that stays up after the second acknowledge. Each directed scenario therefore compares the outputs one clock after each strobe and after each acknowledge.

// File: rtl/spm_pkg.sv
// Package: shared constants and match codes for the special character matcher.
// Assumes four character slots; code values are visible to software.
package spm_pkg;
    localparam int NUM_SLOTS = 4;
    localparam int CODE_W    = 3;

    typedef enum logic [CODE_W-1:0] {
        MC_NONE = 3'd0,
        MC_S1   = 3'd1,
        MC_S2   = 3'd2,
        MC_S3   = 3'd3,
        MC_S4   = 3'd4,
        MC_PAIR = 3'd5
    } match_code_e;
endpackage

// File: rtl/spm_compare.sv
// Module: per-slot equality compare of the received character.
// Assumes the claim mask removes a slot entirely; output is not gated by rx_good.
module spm_compare #(
    parameter int DATA_W = 8,
    parameter int NSLOT  = spm_pkg::NUM_SLOTS
) (
    input  logic [DATA_W-1:0]            data,
    input  logic [NSLOT-1:0][DATA_W-1:0] slots,
    input  logic [NSLOT-1:0]             claim,
    output logic [NSLOT-1:0]             hit
);
    // one comparator per slot
    for (genvar i = 0; i < NSLOT; i++) begin : g_cmp
        assign hit[i] = !claim[i] && (data == slots[i]);
    end
endmodule

// File: rtl/spm_event.sv
// Module: turns slot hits into flow pulses, a suppress flag and host events.
// Assumes hit vector is already masked; keeps the one-deep sequence arm state.
module spm_event
    import spm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 strobe,
    input  logic                 good,
    input  logic [NUM_SLOTS-1:0] hit,
    input  logic                 flow_en,
    input  logic                 seq_mode,
    output logic                 xon,
    output logic                 xoff,
    output logic                 suppress,
    output logic                 ev_valid,
    output match_code_e          ev_code
);
    logic [NUM_SLOTS-1:0] ghit;
    logic                 flow_char;
    logic                 armed;

    assign ghit      = good ? hit : '0;
    assign flow_char = flow_en && (ghit[0] || ghit[1]);
    assign xoff      = strobe && flow_char && ghit[1];
    assign xon       = strobe && flow_char && ghit[0] && !ghit[1];
    assign suppress  = strobe && flow_char;

    // pick one host event per clean character, lowest slot first
    always_comb begin
        ev_code = MC_NONE;
        if (strobe && good && !flow_char) begin
            if (!flow_en && ghit[0])      ev_code = MC_S1;
            else if (!flow_en && ghit[1]) ev_code = MC_S2;
            else if (seq_mode) begin
                if (armed && ghit[3])     ev_code = MC_PAIR;
            end
            else if (ghit[2])             ev_code = MC_S3;
            else if (ghit[3])             ev_code = MC_S4;
        end
    end
    assign ev_valid = (ev_code != MC_NONE);

    // sequence arm: set by an unconsumed slot-3 character, cleared by anything else
    always_ff @(posedge clk) begin
        if (!rst_n)        armed <= 1'b0;
        else if (strobe)   armed <= seq_mode && ghit[2] && (ev_code == MC_NONE)
                                    && !flow_char;
        else if (!seq_mode) armed <= 1'b0;
    end

    a_r1_bad_char_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !good) |-> (!ev_valid && !suppress && !xon && !xoff));
    a_r7_arm_needs_seq: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_mode && !strobe) |=> !armed);
    a_r7_pair_only_armed: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_code == MC_PAIR) |-> (seq_mode && armed));
    a_r4_suppress_flow_only: assert property (@(posedge clk) disable iff (!rst_n)
        suppress |-> (flow_en && !ev_valid));
endmodule

// File: rtl/spm_flow_ctl.sv
// Module: transmit-enable state driven by in-band pause/resume pulses.
// Assumes xon and xoff are never high together; enable is forced on without flow mode.
module spm_flow_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic flow_en,
    input  logic xon,
    input  logic xoff,
    output logic tx_en
);
    // pause on xoff, resume on xon, free-run when flow mode is off
    always_ff @(posedge clk) begin
        if (!rst_n)        tx_en <= 1'b1;
        else if (!flow_en) tx_en <= 1'b1;
        else if (xoff)     tx_en <= 1'b0;
        else if (xon)      tx_en <= 1'b1;
    end

    a_r3_xoff_pauses: assert property (@(posedge clk) disable iff (!rst_n)
        xoff |=> !tx_en);
    a_r3_xon_resumes: assert property (@(posedge clk) disable iff (!rst_n)
        xon |=> tx_en);
    a_r5_free_run: assert property (@(posedge clk) disable iff (!rst_n)
        !flow_en |=> tx_en);
    a_r3_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(xon && xoff));
endmodule

// File: rtl/spm_exc_queue.sv
// Module: small in-order queue of pending host exception codes.
// Assumes an ack without a pending entry is ignored; a push into a full queue is dropped.
module spm_exc_queue #(
    parameter int DEPTH = 2,
    parameter int CW    = spm_pkg::CODE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [CW-1:0] push_code,
    input  logic          ack,
    output logic          req,
    output logic [CW-1:0] code
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int NW = $clog2(DEPTH + 1);

    logic [CW-1:0] mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [NW-1:0] count;
    logic          pop, do_push;

    assign pop     = ack && (count != '0);
    assign do_push = push && ((count != NW'(DEPTH)) || pop);
    assign req     = (count != '0);
    assign code    = req ? mem[rd_ptr] : '0;

    // pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (pop)
                rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (do_push)
                wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            count <= count + NW'(do_push) - NW'(pop);
        end
    end

    // entry storage write
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_code;
    end

    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= NW'(DEPTH));
    a_r9_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack) |=> (req && $stable(code)));
    a_r9_push_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !req) |=> req);
endmodule

// File: rtl/spchar_flow_matcher.sv
// Module: top of the special character matcher for one receive channel.
// Assumes rx_valid is a one-cycle strobe and slot registers are quasi-static.
module spchar_flow_matcher
    import spm_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int EXC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_good,
    input  logic [DATA_W-1:0] slot1_char,
    input  logic [DATA_W-1:0] slot2_char,
    input  logic [DATA_W-1:0] slot3_char,
    input  logic [DATA_W-1:0] slot4_char,
    input  logic [3:0]        slot_tx_claim,
    input  logic              flow_en,
    input  logic              seq_mode,
    input  logic              exc_ack,
    output logic              exc_req,
    output logic [2:0]        exc_code,
    output logic              tx_en,
    output logic              suppress
);
    logic [NUM_SLOTS-1:0][DATA_W-1:0] slots;
    logic [NUM_SLOTS-1:0]             hit;
    logic                             xon, xoff, ev_valid;
    match_code_e                      ev_code;

    assign slots = {slot4_char, slot3_char, slot2_char, slot1_char};

    spm_compare #(.DATA_W(DATA_W), .NSLOT(NUM_SLOTS)) u_cmp (
        .data  (rx_data),
        .slots (slots),
        .claim (slot_tx_claim),
        .hit   (hit)
    );

    spm_event u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (rx_valid),
        .good     (rx_good),
        .hit      (hit),
        .flow_en  (flow_en),
        .seq_mode (seq_mode),
        .xon      (xon),
        .xoff     (xoff),
        .suppress (suppress),
        .ev_valid (ev_valid),
        .ev_code  (ev_code)
    );

    spm_flow_ctl u_flow (
        .clk     (clk),
        .rst_n   (rst_n),
        .flow_en (flow_en),
        .xon     (xon),
        .xoff    (xoff),
        .tx_en   (tx_en)
    );

    spm_exc_queue #(.DEPTH(EXC_DEPTH), .CW(CODE_W)) u_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (ev_valid),
        .push_code (ev_code),
        .ack       (exc_ack),
        .req       (exc_req),
        .code      (exc_code)
    );

    a_r8_claimed_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && slot_tx_claim[1] && flow_en && (rx_data != slot1_char)) |=>
        ($stable(tx_en) || tx_en));
    a_r2_code_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_req |-> (exc_code == 3'd0));
endmodule

// File: tb/sim_spchar_flow_matcher.sv
module sim_spchar_flow_matcher;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_good = 1'b0;
    logic [7:0] s1 = 8'h11, s2 = 8'h13, s3 = 8'h41, s4 = 8'h42;
    logic [3:0] claim = 4'b0000;
    logic       flow_en = 1'b0;
    logic       seq_mode = 1'b0;
    logic       exc_ack = 1'b0;
    logic       exc_req, tx_en, suppress;
    logic [2:0] exc_code;
    logic       sup_seen;
    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;   // 250 MHz

    spchar_flow_matcher u0 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_good(rx_good), .slot1_char(s1), .slot2_char(s2), .slot3_char(s3),
        .slot4_char(s4), .slot_tx_claim(claim), .flow_en(flow_en),
        .seq_mode(seq_mode), .exc_ack(exc_ack), .exc_req(exc_req),
        .exc_code(exc_code), .tx_en(tx_en), .suppress(suppress)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // strobe one character; returns at the negedge after the capturing edge
    task automatic send(input logic [7:0] c, input logic good);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = c; rx_good = good;
        #1 sup_seen = suppress;
        @(negedge clk);
        rx_valid = 1'b0; rx_good = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk); exc_ack = 1'b1;
        @(negedge clk); exc_ack = 1'b0;
    endtask

    task automatic t_reset();
        check("R2 tx_en", tx_en, 1);
        check("R2 exc_req", exc_req, 0);
        check("R2 exc_code", exc_code, 0);
    endtask

    task automatic t_flow();
        flow_en = 1'b1;
        send(8'h13, 1'b1);
        check("R4 suppress xoff", sup_seen, 1);
        check("R3 xoff clears", tx_en, 0);
        check("R3 no exception", exc_req, 0);
        send(8'h13, 1'b0);
        check("R1 bad no suppress", sup_seen, 0);
        send(8'h11, 1'b0);
        check("R1 bad xon ignored", tx_en, 0);
        send(8'h11, 1'b1);
        check("R3 xon sets", tx_en, 1);
        check("R4 suppress xon", sup_seen, 1);
        send(8'h20, 1'b1);
        check("R4 plain no suppress", sup_seen, 0);
        s1 = 8'h55; s2 = 8'h55;
        send(8'h55, 1'b1);
        check("R3 xoff wins", tx_en, 0);
        s1 = 8'h11; s2 = 8'h13;
        send(8'h11, 1'b1);
        check("R3 resume", tx_en, 1);
    endtask

    task automatic t_claim();
        flow_en = 1'b1; claim = 4'b0010;
        send(8'h13, 1'b1);
        check("R8 claimed xoff no suppress", sup_seen, 0);
        check("R8 claimed xoff tx_en", tx_en, 1);
        claim = 4'b0100; flow_en = 1'b0;
        send(8'h41, 1'b1);
        check("R8 claimed slot3 no req", exc_req, 0);
        claim = 4'b0000;
    endtask

    task automatic t_noflow();
        flow_en = 1'b1;
        send(8'h13, 1'b1);
        flow_en = 1'b0;
        @(negedge clk);
        check("R5 forced on", tx_en, 1);
        send(8'h13, 1'b1);
        check("R5 tx_en held", tx_en, 1);
        check("R5 slot2 code", exc_code, 2);
        check("R4 no suppress when off", sup_seen, 0);
        ack();
        send(8'h11, 1'b1);
        check("R5 slot1 code", exc_code, 1);
        ack();
        check("R9 ack retires", exc_req, 0);
    endtask

    task automatic t_single();
        seq_mode = 1'b0;
        send(8'h41, 1'b1);
        check("R6 slot3 code", exc_code, 3);
        check("R9 req raised", exc_req, 1);
        repeat (3) @(negedge clk);
        check("R9 code held", exc_code, 3);
        ack();
        send(8'h42, 1'b1);
        check("R6 slot4 code", exc_code, 4);
        ack();
        s4 = 8'h41;
        send(8'h41, 1'b1);
        check("R6 lowest slot", exc_code, 3);
        ack();
        check("R6 single event", exc_req, 0);
        s4 = 8'h42;
        send(8'h41, 1'b0);
        check("R1 bad no event", exc_req, 0);
    endtask

    task automatic t_seq();
        seq_mode = 1'b1;
        send(8'h41, 1'b1);
        check("R7 head alone silent", exc_req, 0);
        send(8'h42, 1'b1);
        check("R7 pair code", exc_code, 5);
        ack();
        check("R7 pair retired", exc_req, 0);
        send(8'h41, 1'b1); send(8'h20, 1'b1); send(8'h42, 1'b1);
        check("R7 gap cancels", exc_req, 0);
        send(8'h41, 1'b1); send(8'h42, 1'b0); send(8'h42, 1'b1);
        check("R1 bad char cancels pair", exc_req, 0);
        send(8'h41, 1'b1); send(8'h41, 1'b1); send(8'h42, 1'b1);
        check("R7 rearm pair", exc_code, 5);
        ack();
        claim = 4'b1000;
        send(8'h41, 1'b1); send(8'h42, 1'b1);
        check("R8 claimed tail no pair", exc_req, 0);
        claim = 4'b0000;
        seq_mode = 1'b0;
    endtask

    task automatic t_queue();
        send(8'h41, 1'b1); send(8'h42, 1'b1); send(8'h41, 1'b1);
        check("R10 first in order", exc_code, 3);
        ack();
        check("R10 second in order", exc_code, 4);
        ack();
        check("R10 third dropped", exc_req, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_flow();
        t_claim();
        t_noflow();
        t_single();
        t_seq();
        t_queue();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule